// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Pending Bank

This block keeps one 32-bit pending-interrupt word for each of up to sixteen processors. Software reaches the words through a single-cycle memory-mapped register port. Each processor owns a 4 KB page of that port's address space. Within a page, software can read the pending word. It can also raise or drop software-interrupt bits through two separate word offsets. Software can only ever affect bits 31 through 17.

A second, hardware-facing port lets a companion source router raise or drop one interrupt level bit, from 1 to 15, in any chosen processor's word. Every word is also driven out in parallel, so that downstream priority logic sees the current pending state of each processor. Both ports may act on the same word in the same cycle, and both updates land together.

Top module: `sirq_bank`

## Requirements
- R1: While reset is held, every pending word and the read data return to zero.
- R2: A read (valid high, write low) with address bits [3:2] equal to 0 returns, in the following cycle, the pending word of the processor selected by address bits [15:12]. Any other offset, any write, and any idle cycle give zero read data in the following cycle. Address bits [11:4] and [1:0] are ignored.
- R3: A write at offset 1 (address bits [3:2] = 1) clears each pending bit at positions 31..17 where the write data holds a 1. Bits 16..0 are left untouched.
- R4: A write at offset 2 sets each pending bit at positions 31..17 where the write data holds a 1. Bits 16..0 are left untouched.
- R5: Writes at offset 0 and at offset 3 change no pending word.
- R6: A software access affects only the processor whose page is addressed. A page index at or above the processor count is ignored.
- R7: A hardware update with valid high sets bit [level] of processor [cpu] when its set flag is 1, and clears that bit when the flag is 0. The bit takes its new value at the next clock edge.
- R8: A hardware update with level 0, or with a processor index at or above the processor count, has no effect.
- R9: A software write and a hardware update to the same word in the same cycle both take effect. The hardware update is applied last on any bit both touch.
- R10: Slice [32*i+31 : 32*i] of the parallel output always equals processor i's pending word. It reflects an update from the cycle after the edge that captured it.
- R11: With valid low, the register port changes no pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Byte address; [15:12] page/processor, [3:2] word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| hw_valid | input | 1 | Hardware level update strobe |
| hw_cpu | input | 4 | Target processor of the hardware update |
| hw_level | input | 4 | Level bit to update (1..15) |
| hw_set | input | 1 | 1 = set the level bit, 0 = clear it |
| pend_out | output | 512 | All pending words, processor i in bits 32*i+31:32*i |

## Verification
Every result here is due exactly one clock edge after its stimulus. This holds for a pending-word change from either port, seen on the parallel output, and for read data. The bench drives each stimulus on a falling edge and holds it through one rising edge. It then samples the outputs at the next falling edge, where both the registered read data and the updated words are settled. To prove that an ignored access had no effect, the bench checks the parallel output after it. It also reads the word back through the register port in a later cycle.

// File: rtl/sirq_pkg.sv
// Package: shared constants and types for the soft interrupt bank.
// Assumes a 32-bit data path and at most sixteen 4 KB processor pages.
package sirq_pkg;

    // Width of the processor index field in the address and on the hw port
    localparam int IDX_W   = 4;
    // Width of the hardware level field
    localparam int LEVEL_W = 4;
    // Highest processor count the page field can address
    localparam int MAX_CPU = 1 << IDX_W;

    // Word offsets inside a processor page (address bits [3:2])
    typedef enum logic [1:0] {
        OFF_PEND = 2'd0,   // read pending word
        OFF_CLR  = 2'd1,   // clear software bits
        OFF_SET  = 2'd2,   // set software bits
        OFF_RSVD = 2'd3    // reserved, no effect
    } sirq_off_e;

    // Mask of the software-writable bits: [dw-1 : lsb]
    function automatic logic [63:0] sw_mask(input int dw, input int lsb);
        logic [63:0] m;
        m = '0;
        for (int b = 0; b < dw; b++) begin
            if (b >= lsb) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sirq_decode.sv
// Module: sirq_decode
// Decodes a register-port access into a one-hot processor select and
// clear / set / read strobes. Assumes the page index sits at PAGE_LSB
// and the word offset at bits [3:2]; other address bits are ignored.
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int NUM_CPU  = 16,
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 12
) (
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [ADDR_W-1:0]  reg_addr,
    output logic [NUM_CPU-1:0] cpu_sel,
    output logic [IDX_W-1:0]   cpu_idx,
    output logic               in_range,
    output logic               do_clr,
    output logic               do_set,
    output logic               do_rd
);

    sirq_off_e off;
    logic      unused_addr;

    // Split the address into page index and word offset
    always_comb begin
        cpu_idx     = reg_addr[PAGE_LSB +: IDX_W];
        off         = sirq_off_e'(reg_addr[3:2]);
        in_range    = ({1'b0, cpu_idx} < (IDX_W+1)'(NUM_CPU));
        unused_addr = ^{reg_addr[ADDR_W-1:PAGE_LSB+IDX_W], reg_addr[PAGE_LSB-1:4], reg_addr[1:0]};
    end

    // Classify the access by direction and offset
    always_comb begin
        do_clr = reg_valid &&  reg_write && in_range && (off == OFF_CLR);
        do_set = reg_valid &&  reg_write && in_range && (off == OFF_SET);
        do_rd  = reg_valid && !reg_write && in_range && (off == OFF_PEND);
    end

    // One-hot processor select, one comparator per processor
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
        assign cpu_sel[i] = in_range && (cpu_idx == IDX_W'(i));
    end

endmodule

// File: rtl/sirq_cell.sv
// Module: sirq_cell
// Holds one processor's pending word. The software clear/set terms
// touch only bits [DATA_W-1:SW_LSB]; the hardware term touches one
// level bit and is applied last, so it wins on any shared bit.
module sirq_cell
    import sirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SW_LSB = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_clr,
    input  logic               sw_set,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               hw_hit,
    input  logic               hw_set,
    input  logic [LEVEL_W-1:0] hw_level,
    output logic [DATA_W-1:0]  pend
);

    localparam logic [63:0]       MASK64  = sw_mask(DATA_W, SW_LSB);
    localparam logic [DATA_W-1:0] SW_MASK = MASK64[DATA_W-1:0];

    logic [DATA_W-1:0] sw_bits;
    logic [DATA_W-1:0] hw_bit;
    logic [DATA_W-1:0] after_sw;
    logic [DATA_W-1:0] nxt;

    // Restrict software data to its writable field and form the level bit
    always_comb begin
        sw_bits = wdata & SW_MASK;
        hw_bit  = DATA_W'(1) << hw_level;
    end

    // Apply software clear, then software set, then the hardware update
    always_comb begin
        after_sw = pend;
        if (sw_clr) after_sw = after_sw & ~sw_bits;
        if (sw_set) after_sw = after_sw | sw_bits;
        nxt = after_sw;
        if (hw_hit) nxt = hw_set ? (nxt | hw_bit) : (nxt & ~hw_bit);
    end

    // Pending word register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= nxt;
    end

endmodule

// File: rtl/sirq_rdmux.sv
// Module: sirq_rdmux
// Selects the addressed processor's word and registers it as read data.
// Assumes the decoder has already qualified the read (offset and range);
// an unqualified cycle yields zero.
module sirq_rdmux
    import sirq_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic [NUM_CPU*DATA_W-1:0] pend_flat,
    output logic [DATA_W-1:0]         rdata
);

    logic [DATA_W-1:0] picked;

    // Pick the addressed word with an AND-OR tree
    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (rd_idx == IDX_W'(i)) picked = picked | pend_flat[i*DATA_W +: DATA_W];
        end
    end

    // Register read data; zero whenever no qualified read happened
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= picked;
        else            rdata <= '0;
    end

endmodule

// File: rtl/sirq_bank.sv
// Module: sirq_bank (top)
// Bank of per-processor pending words, written by a register port and a
// hardware level port, read back through the register port and driven out
// in parallel. Assumes NUM_CPU <= 16 and one access per port per cycle.
module sirq_bank
    import sirq_pkg::*;
#(
    parameter int NUM_CPU  = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 12,
    parameter int SW_LSB   = 17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_valid,
    input  logic                      reg_write,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic                      hw_valid,
    input  logic [IDX_W-1:0]          hw_cpu,
    input  logic [LEVEL_W-1:0]        hw_level,
    input  logic                      hw_set,
    output logic [NUM_CPU*DATA_W-1:0] pend_out
);

    logic [NUM_CPU-1:0] cpu_sel;
    logic [IDX_W-1:0]   cpu_idx;
    logic               in_range;
    logic               do_clr;
    logic               do_set;
    logic               do_rd;
    logic               hw_ok;

    // Register port address decode
    sirq_decode #(
        .NUM_CPU  (NUM_CPU),
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_dec (
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .cpu_sel   (cpu_sel),
        .cpu_idx   (cpu_idx),
        .in_range  (in_range),
        .do_clr    (do_clr),
        .do_set    (do_set),
        .do_rd     (do_rd)
    );

    // Qualify the hardware update: nonzero level and a present processor
    always_comb begin
        hw_ok = hw_valid && (hw_level != '0) &&
                ({1'b0, hw_cpu} < (IDX_W+1)'(NUM_CPU));
    end

    // One pending-word cell per processor
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cell
        sirq_cell #(
            .DATA_W (DATA_W),
            .SW_LSB (SW_LSB)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_clr   (do_clr && cpu_sel[i]),
            .sw_set   (do_set && cpu_sel[i]),
            .wdata    (reg_wdata),
            .hw_hit   (hw_ok && (hw_cpu == IDX_W'(i))),
            .hw_set   (hw_set),
            .hw_level (hw_level),
            .pend     (pend_out[i*DATA_W +: DATA_W])
        );
    end

    // Registered read-back path
    sirq_rdmux #(
        .NUM_CPU (NUM_CPU),
        .DATA_W  (DATA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (do_rd),
        .rd_idx    (cpu_idx),
        .pend_flat (pend_out),
        .rdata     (reg_rdata)
    );

endmodule

// File: rtl/sirq_bank_chk.sv
// Module: sirq_bank_chk
// Property checker for sirq_bank, attached through bind. Observes ports only.
module sirq_bank_chk
    import sirq_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int SW_LSB  = 17
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_valid,
    input logic                      reg_write,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [DATA_W-1:0]         reg_rdata,
    input logic                      hw_valid,
    input logic [IDX_W-1:0]          hw_cpu,
    input logic [LEVEL_W-1:0]        hw_level,
    input logic                      hw_set,
    input logic [NUM_CPU*DATA_W-1:0] pend_out
);

    localparam int TOT_W = NUM_CPU * DATA_W;
    localparam int POS_W = $clog2(TOT_W);

    // Low (hardware-only) bits of every word, replicated across the bank
    function automatic logic [TOT_W-1:0] low_mask_all();
        logic [TOT_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CPU; i++)
            for (int b = 0; b < SW_LSB; b++) m[i*DATA_W + b] = 1'b1;
        return m;
    endfunction
    localparam logic [TOT_W-1:0] LOW_ALL = low_mask_all();

    logic             rst_q;
    logic             hq_valid;
    logic [POS_W-1:0] hq_pos;
    logic             hq_set;

    // Remember that reset was applied at the previous edge
    always_ff @(posedge clk) rst_q <= !rst_n;

    // Capture the last accepted hardware update for a next-cycle check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hq_valid <= 1'b0;
            hq_pos   <= '0;
            hq_set   <= 1'b0;
        end else begin
            hq_valid <= hw_valid && (hw_level != '0) &&
                        ({1'b0, hw_cpu} < (IDX_W+1)'(NUM_CPU));
            hq_pos   <= POS_W'(hw_cpu) * POS_W'(DATA_W) + POS_W'(hw_level);
            hq_set   <= hw_set;
        end
    end

    // Reset state check one edge after reset was sampled
    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_CLEAR: assert (pend_out == '0 && reg_rdata == '0); // R1
        end
    end

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && !reg_write && reg_addr[3:2] == 2'd0) |=> (reg_rdata == '0)); // R2

    AST_SW_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_valid) |=> $stable(pend_out & LOW_ALL)); // R3

    AST_PORT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_valid && !(reg_valid && reg_write)) |=> $stable(pend_out)); // R11

    AST_HW_LEVEL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        hq_valid |-> (pend_out[hq_pos] == hq_set)); // R7

    AST_RSVD_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_valid && reg_valid && reg_write && (reg_addr[3:2] == 2'd0 || reg_addr[3:2] == 2'd3))
        |=> $stable(pend_out)); // R5

endmodule

bind sirq_bank sirq_bank_chk #(
    .NUM_CPU (NUM_CPU),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SW_LSB  (SW_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .hw_valid  (hw_valid),
    .hw_cpu    (hw_cpu),
    .hw_level  (hw_level),
    .hw_set    (hw_set),
    .pend_out  (pend_out)
);

// File: tb/tb_sirq_bank.sv
`timescale 1ns/1ps
module tb_sirq_bank;

    localparam int NCPU = 16;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_valid = 1'b0;
    logic            reg_write = 1'b0;
    logic [15:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            hw_valid = 1'b0;
    logic [3:0]      hw_cpu = '0;
    logic [3:0]      hw_level = '0;
    logic            hw_set = 1'b0;
    logic [NCPU*DW-1:0] pend_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sirq_bank dut (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_valid(hw_valid), .hw_cpu(hw_cpu), .hw_level(hw_level), .hw_set(hw_set),
        .pend_out(pend_out)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;   // expected read data for reads
        logic [7:0]  req;
    } vec_t;

    // Software-port vectors: writes, then read-backs with expected words
    localparam vec_t VECS [14] = '{
        '{1'b0, 16'h0000, 32'h0,          32'h0000_0000, 8'd1},  // R1 cpu0 clear
        '{1'b1, 16'h3008, 32'hFFFF_FFFF,  32'h0,         8'd4},  // R4 set all sw bits cpu3
        '{1'b0, 16'h3000, 32'h0,          32'hFFFE_0000, 8'd4},  // R4
        '{1'b0, 16'h3004, 32'h0,          32'h0000_0000, 8'd2},  // R2 non-zero offset reads 0
        '{1'b0, 16'h2000, 32'h0,          32'h0000_0000, 8'd6},  // R6 neighbour untouched
        '{1'b1, 16'h3004, 32'h8001_FFFF,  32'h0,         8'd3},  // R3 clear bit31 only
        '{1'b0, 16'h3000, 32'h0,          32'h7FFE_0000, 8'd3},  // R3
        '{1'b1, 16'h3000, 32'h0000_0000,  32'h0,         8'd5},  // R5 offset0 write
        '{1'b1, 16'h300C, 32'hFFFF_FFFF,  32'h0,         8'd5},  // R5 offset3 write
        '{1'b0, 16'h3000, 32'h0,          32'h7FFE_0000, 8'd5},  // R5
        '{1'b1, 16'hF008, 32'h0002_0000,  32'h0,         8'd6},  // R6 last page
        '{1'b0, 16'hF000, 32'h0,          32'h0002_0000, 8'd6},  // R6
        '{1'b0, 16'h3000, 32'h0,          32'h7FFE_0000, 8'd6},  // R6
        '{1'b0, 16'h3FF1, 32'h0,          32'h7FFE_0000, 8'd2}   // R2 ignored addr bits
    };

    function automatic logic [31:0] word(input int c);
        return pend_out[c*DW +: DW];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One cycle of stimulus on both ports; returns at the following falling edge
    task automatic cyc(input logic sv, input logic sw, input logic [15:0] sa, input logic [31:0] sd,
                       input logic hv, input logic [3:0] hc, input logic [3:0] hl, input logic hs);
        @(negedge clk);
        reg_valid = sv; reg_write = sw; reg_addr = sa; reg_wdata = sd;
        hw_valid = hv; hw_cpu = hc; hw_level = hl; hw_set = hs;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; hw_valid = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
        cyc(1'b1, 1'b0, a, '0, 1'b0, '0, '0, 1'b0);
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pend", word(0) | word(7) | word(15), 32'h0);
        chk("R1 rdata", reg_rdata, 32'h0);
        rst_n = 1'b1;

        // Table walk
        foreach (VECS[k]) begin
            cyc(1'b1, VECS[k].wr, VECS[k].addr, VECS[k].data, 1'b0, '0, '0, 1'b0);
            if (!VECS[k].wr) chk($sformatf("R%0d vec%0d", VECS[k].req, k), reg_rdata, VECS[k].exp);
            else             chk("R2 write rdata", reg_rdata, 32'h0);
        end
        chk("R10 slice3", word(3), 32'h7FFE_0000);
        chk("R10 slice15", word(15), 32'h0002_0000);

        // R7: hardware set / clear, R10 slice visible next cycle
        cyc(1'b0, 1'b0, '0, '0, 1'b1, 4'd5, 4'd7, 1'b1);
        chk("R7 set lvl7", word(5), 32'h0000_0080);
        chk("R10 other slice", word(4), 32'h0);
        rd(16'h5000, 32'h0000_0080, "R2 readback hw");
        cyc(1'b0, 1'b0, '0, '0, 1'b1, 4'd5, 4'd7, 1'b0);
        chk("R7 clear lvl7", word(5), 32'h0);
        cyc(1'b0, 1'b0, '0, '0, 1'b1, 4'd5, 4'd15, 1'b1);
        chk("R7 lvl15", word(5), 32'h0000_8000);

        // R8: level 0 ignored
        cyc(1'b0, 1'b0, '0, '0, 1'b1, 4'd5, 4'd0, 1'b1);
        chk("R8 level0", word(5), 32'h0000_8000);

        // R9: simultaneous software set and hardware set on the same word
        cyc(1'b1, 1'b1, 16'h5008, 32'h0006_0000, 1'b1, 4'd5, 4'd3, 1'b1);
        chk("R9 both set", word(5), 32'h0006_8008);
        cyc(1'b1, 1'b1, 16'h5004, 32'h0002_0000, 1'b1, 4'd5, 4'd15, 1'b0);
        chk("R9 both clear", word(5), 32'h0004_0008);

        // R3: software clear cannot reach low bits
        cyc(1'b1, 1'b1, 16'h5004, 32'h0000_FFFF, 1'b0, '0, '0, 1'b0);
        chk("R3 low kept", word(5), 32'h0004_0008);

        // R11: valid low write ignored
        cyc(1'b0, 1'b1, 16'h5008, 32'hFFFF_FFFF, 1'b0, '0, '0, 1'b0);
        chk("R11 idle write", word(5), 32'h0004_0008);
        rd(16'h5000, 32'h0004_0008, "R11 readback");

        // R1: reset applied again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 re-reset slice3", word(3), 32'h0);
        chk("R1 re-reset slice5", word(5), 32'h0);
        rst_n = 1'b1;
        rd(16'hF000, 32'h0, "R1 re-reset readback");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule